// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block produces the instruction address for a small 8-bit controller core. It keeps a 13-bit program counter that normally steps by one per enabled cycle. The counter can also be reloaded in four ways:

- a register write to its low byte;
- an absolute jump or call whose 11-bit target comes from the instruction;
- an interrupt that branches to a vector;
- a return that takes the address from an internal return stack.

The upper counter bits are never written directly. They always come from an external 5-bit high-latch register, and which latch bits are used depends on the kind of load.

The return stack holds eight 13-bit addresses and is invisible to software. It behaves as a ring. Pushes past the eighth overwrite the oldest entries, and pops past the bottom keep wrapping. No overflow or underflow indication exists. A computed jump is an ordinary low-byte write of an offset-adjusted value. Any carry out of the low byte is lost, so a lookup table that straddles a 256-address boundary lands in the wrong block.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_ni` is low, the PC is 0 at once, and every stack entry and the stack pointer are cleared. A return right after reset therefore loads 0.
- R2: With `inc_en_i` high and no other request, the PC becomes PC+1 at the next clock, wrapping from 13'h1FFF to 13'h0000. With no request, the PC holds.
- R3: A low-byte write loads PC[7:0] from `low_wdata_i` and PC[12:8] from `hi_latch_i[4:0]`. `pc_lo_o` always equals PC[7:0].
- R4: A jump loads PC[10:0] from `target_i` and PC[12:11] from `hi_latch_i[4:3]`. Latch bits 2:0 have no effect on a jump.
- R5: A call (`jump_i` and `call_i` both high) pushes PC+1 and then jumps as in R4. A later return (`ret_i`) loads that pushed address.
- R6: An interrupt (`irq_i`) pushes the current PC and loads `vector_i`.
- R7: Up to eight nested pushes are returned in last-in, first-out order.
- R8: After nine pushes, the ninth push has overwritten the first. Nine pops then return the 9th, 8th, … 2nd pushed values, followed by the 9th value again.
- R9: When several requests coincide, the priority is interrupt, then return, then jump/call, then low-byte write, then increment. A request that loses to another has no effect on the PC or the stack.
- R10: A computed jump written as low byte (PC[7:0]+offset) mod 256 keeps PC[12:8] from the latch and discards the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_en_i | input | 1 | Step PC by one |
| low_wr_i | input | 1 | Write strobe for PC low byte |
| low_wdata_i | input | 8 | Data for PC low byte |
| jump_i | input | 1 | Absolute jump or call load |
| call_i | input | 1 | With jump_i: push return address |
| target_i | input | 11 | Instruction target field |
| irq_i | input | 1 | Interrupt branch with push |
| vector_i | input | 13 | Interrupt vector address |
| ret_i | input | 1 | Return: pop stack into PC |
| hi_latch_i | input | 5 | High-latch register value |
| pc_o | output | 13 | Current program counter |
| pc_lo_o | output | 8 | Low-byte readback |

## Verification
Each load, push and pop passes through exactly one register. A request present at a rising edge is therefore visible on `pc_o` right after that edge, and a popped value appears in the same cycle as the return. Reset is the exception: it acts asynchronously and clears the counter without waiting for a clock. The bench changes inputs only at falling edges, applies each request for exactly one rising edge, and compares outputs at the following falling edge. Stack contents are observed only through returns, each one a separate cycle.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_INC,
    SEL_LOW,
    SEL_JMP,
    SEL_POP,
    SEL_VEC
  } pc_sel_e;
endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
  import pcseq_pkg::*;
(
  input  logic    irq_i,
  input  logic    ret_i,
  input  logic    jump_i,
  input  logic    call_i,
  input  logic    low_wr_i,
  input  logic    inc_en_i,
  output pc_sel_e sel_o,
  output logic    push_o,
  output logic    pop_o
);
  always_comb begin
    sel_o  = SEL_HOLD;
    push_o = 1'b0;
    pop_o  = 1'b0;
    if (irq_i) begin
      sel_o  = SEL_VEC;
      push_o = 1'b1;
    end else if (ret_i) begin
      sel_o = SEL_POP;
      pop_o = 1'b1;
    end else if (jump_i) begin
      sel_o  = SEL_JMP;
      push_o = call_i;
    end else if (low_wr_i) begin
      sel_o = SEL_LOW;
    end else if (inc_en_i) begin
      sel_o = SEL_INC;
    end
  end
endmodule

// File: rtl/pcseq_ring_stack.sv
// DEPTH must be a power of two so the pointer wraps naturally.
module pcseq_ring_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] rd_idx;

  assign rd_idx = ptr_q - PTR_W'(1);
  assign top_o  = mem_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= push_data_i;
      ptr_q        <= ptr_q + PTR_W'(1);
    end else if (pop_i) begin
      ptr_q <= rd_idx;
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int TGT_W = 11,
  parameter int DEPTH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 inc_en_i,
  input  logic                 low_wr_i,
  input  logic [LO_W-1:0]      low_wdata_i,
  input  logic                 jump_i,
  input  logic                 call_i,
  input  logic [TGT_W-1:0]     target_i,
  input  logic                 irq_i,
  input  logic [PC_W-1:0]      vector_i,
  input  logic                 ret_i,
  input  logic [PC_W-LO_W-1:0] hi_latch_i,
  output logic [PC_W-1:0]      pc_o,
  output logic [LO_W-1:0]      pc_lo_o
);
  localparam int HI_W  = PC_W - LO_W;
  localparam int PAG_W = PC_W - TGT_W;

  pc_sel_e         sel;
  logic            push, pop;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, push_data, stack_top;

  pcseq_arbiter u_arb (
    .irq_i   (irq_i),
    .ret_i   (ret_i),
    .jump_i  (jump_i),
    .call_i  (call_i),
    .low_wr_i(low_wr_i),
    .inc_en_i(inc_en_i),
    .sel_o   (sel),
    .push_o  (push),
    .pop_o   (pop)
  );

  pcseq_ring_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .push_data_i(push_data),
    .top_o      (stack_top)
  );

  assign pc_inc    = pc_q + PC_W'(1);
  // interrupt resumes at the instruction not yet run; call resumes after itself
  assign push_data = (sel == SEL_VEC) ? pc_q : pc_inc;

  always_comb begin
    unique case (sel)
      SEL_VEC: pc_d = vector_i;
      SEL_POP: pc_d = stack_top;
      SEL_JMP: pc_d = {hi_latch_i[HI_W-1 -: PAG_W], target_i};
      SEL_LOW: pc_d = {hi_latch_i, low_wdata_i};
      SEL_INC: pc_d = pc_inc;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o    = pc_q;
  assign pc_lo_o = pc_q[LO_W-1:0];
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int TGT_W = 11
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 inc_en_i,
  input logic                 low_wr_i,
  input logic [LO_W-1:0]      low_wdata_i,
  input logic                 jump_i,
  input logic [TGT_W-1:0]     target_i,
  input logic                 irq_i,
  input logic [PC_W-1:0]      vector_i,
  input logic                 ret_i,
  input logic [PC_W-LO_W-1:0] hi_latch_i,
  input logic [PC_W-1:0]      pc_o
);
  localparam int HI_W = PC_W - LO_W;

  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> pc_o == '0);

  p_inc_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_en_i && !irq_i && !ret_i && !jump_i && !low_wr_i)
      |=> pc_o == ($past(pc_o) + 1'b1));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_en_i && !irq_i && !ret_i && !jump_i && !low_wr_i) |=> $stable(pc_o));

  p_low_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_wr_i && !irq_i && !ret_i && !jump_i)
      |=> pc_o == {$past(hi_latch_i), $past(low_wdata_i)});

  p_jump_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !irq_i && !ret_i)
      |=> (pc_o[TGT_W-1:0] == $past(target_i)) &&
          (pc_o[PC_W-1:TGT_W] == $past(hi_latch_i[HI_W-1 -: PC_W-TGT_W])));

  p_irq_vector_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> pc_o == $past(vector_i));
endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .inc_en_i   (inc_en_i),
  .low_wr_i   (low_wr_i),
  .low_wdata_i(low_wdata_i),
  .jump_i     (jump_i),
  .target_i   (target_i),
  .irq_i      (irq_i),
  .vector_i   (vector_i),
  .ret_i      (ret_i),
  .hi_latch_i (hi_latch_i),
  .pc_o       (pc_o)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_en = 1'b0, low_wr = 1'b0, jump = 1'b0, call = 1'b0;
  logic        irq = 1'b0, ret = 1'b0;
  logic [7:0]  low_wdata = '0;
  logic [10:0] target = '0;
  logic [12:0] vector = '0;
  logic [4:0]  latch = '0;
  logic [12:0] pc;
  logic [7:0]  pc_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pc_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n), .inc_en_i(inc_en), .low_wr_i(low_wr),
    .low_wdata_i(low_wdata), .jump_i(jump), .call_i(call), .target_i(target),
    .irq_i(irq), .vector_i(vector), .ret_i(ret), .hi_latch_i(latch),
    .pc_o(pc), .pc_lo_o(pc_lo)
  );

  task automatic chk(string req, logic [12:0] got, logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    inc_en = 0; low_wr = 0; jump = 0; call = 0; irq = 0; ret = 0;
  endtask

  task automatic set_pc(logic [12:0] v);
    latch = v[12:8]; low_wdata = v[7:0]; low_wr = 1; cyc(); idle();
  endtask

  task automatic do_call(logic [10:0] t);
    jump = 1; call = 1; target = t; cyc(); idle();
  endtask

  task automatic do_ret();
    ret = 1; cyc(); idle();
  endtask

  task automatic t_reset_r1();
    chk("R1 pc in reset", pc, 13'h0000);
    @(negedge clk); rst_n = 1;
    cyc();
    chk("R1 pc after release", pc, 13'h0000);
    do_ret();
    chk("R1 pop after reset", pc, 13'h0000);
    set_pc(13'h0ABC);
    #1 rst_n = 0;
    #0.5 chk("R1 async clear", pc, 13'h0000);
    @(negedge clk); rst_n = 1;
    cyc();
  endtask

  task automatic t_inc_r2();
    set_pc(13'h0010);
    inc_en = 1; cyc(); cyc(); idle();
    chk("R2 increment", pc, 13'h0012);
    cyc(); cyc();
    chk("R2 hold", pc, 13'h0012);
    set_pc(13'h1FFF);
    inc_en = 1; cyc(); idle();
    chk("R2 wrap", pc, 13'h0000);
  endtask

  task automatic t_low_r3();
    latch = 5'h15; low_wdata = 8'hC3; low_wr = 1; cyc(); idle();
    chk("R3 low write", pc, 13'h15C3);
    chk("R3 low readback", {5'h0, pc_lo}, 13'h00C3);
  endtask

  task automatic t_jump_r4();
    latch = 5'h1F; jump = 1; target = 11'h0AA; cyc(); idle();
    chk("R4 jump latch bits 4:3", pc, 13'h18AA);
    latch = 5'h07; jump = 1; target = 11'h7FF; cyc(); idle();
    chk("R4 latch bits 2:0 ignored", pc, 13'h07FF);
  endtask

  task automatic t_call_r5();
    set_pc(13'h0123);
    latch = 5'h08; do_call(11'h400);
    chk("R5 call target", pc, 13'h0C00);
    do_ret();
    chk("R5 return address", pc, 13'h0124);
  endtask

  task automatic t_irq_r6();
    set_pc(13'h0456);
    vector = 13'h0004; irq = 1; cyc(); idle();
    chk("R6 vector", pc, 13'h0004);
    do_ret();
    chk("R6 resumes at interrupted pc", pc, 13'h0456);
  endtask

  task automatic t_nest_r7();
    for (int i = 0; i < 8; i++) begin
      set_pc(13'(i * 16));
      latch = 0; do_call(11'h700);
    end
    for (int k = 0; k < 8; k++) begin
      do_ret();
      chk("R7 lifo order", pc, 13'((7 - k) * 16 + 1));
    end
  endtask

  task automatic t_ring_r8();
    for (int i = 1; i <= 9; i++) begin
      set_pc(13'(i * 32));
      latch = 0; do_call(11'h600);
    end
    for (int k = 0; k < 8; k++) begin
      do_ret();
      chk("R8 ring pop", pc, 13'((9 - k) * 32 + 1));
    end
    do_ret();
    chk("R8 ninth pop wraps", pc, 13'(9 * 32 + 1));
  endtask

  task automatic t_prio_r9();
    set_pc(13'h0020);
    latch = 0; vector = 13'h0004; target = 11'h155; low_wdata = 8'h33;
    irq = 1; ret = 1; jump = 1; call = 1; low_wr = 1; inc_en = 1; cyc(); idle();
    chk("R9 irq wins", pc, 13'h0004);
    ret = 1; jump = 1; call = 1; low_wr = 1; inc_en = 1; cyc(); idle();
    chk("R9 ret over call", pc, 13'h0020);
    jump = 1; low_wr = 1; inc_en = 1; cyc(); idle();
    chk("R9 jump over write", pc, 13'h0155);
    low_wr = 1; inc_en = 1; cyc(); idle();
    chk("R9 write over inc", pc, 13'h0033);
    set_pc(13'h0777);
    latch = 0; do_call(11'h100);
    ret = 1; jump = 1; call = 1; target = 11'h200; cyc(); idle();
    chk("R9 losing call no push", pc, 13'h0778);
  endtask

  task automatic t_computed_r10();
    logic [7:0] lo;
    set_pc(13'h0110);
    lo = pc_lo + 8'hF8;
    latch = 5'h01; low_wdata = lo; low_wr = 1; cyc(); idle();
    chk("R10 carry dropped", pc, 13'h0108);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    t_inc_r2();
    t_low_r3();
    t_jump_r4();
    t_call_r5();
    t_irq_r6();
    t_nest_r7();
    t_ring_r8();
    t_prio_r9();
    t_computed_r10();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule